// File: doc/BRIEF.md
# Two-Sided Mailbox Messaging Unit

The block joins two processors, called side A and side B, that share one clock. Each side sees the same small register window. It holds four outgoing data words, four incoming data words, a status word and a control word. A word that one side writes into its outgoing slot n shows up in incoming slot n on the other side.

Each slot has a handshake flag. The sender sees an "empty" flag for its outgoing slot, and the receiver sees a "full" flag for its incoming slot. The flag is set by the sender's write and cleared by the receiver's read. Each slot also has its own interrupt enable on each side. This lets a message spread over several slots raise a single interrupt when its final word lands.

Besides the data path there are four doorbells per direction. A side sets a request bit in its own control word. A pending bit then appears in the other side's status word and stays there until that side clears it. Each side has one interrupt output. It is the registered OR of every enabled source.

Top module: `ipcm_top`

## Requirements
- R1: Outgoing slot n is at byte offset 4n (0x00–0x0C) and incoming slot n is at 0x10+4n (0x10–0x1C). A word written to outgoing slot n on one side is read back from incoming slot n on the other side, in both directions.
- R2: Status bit 20+(3-n) is the empty flag of outgoing slot n. It reads 0 from the cycle after a local write to that slot. It reads 1 again from the cycle after the partner reads its incoming slot n.
- R3: Status bit 24+(3-n) is the full flag of incoming slot n. It reads 1 from the cycle after the partner writes slot n and reads 0 from the cycle after a local read of slot n. A read while the flag is 0 returns the last word received.
- R4: Control bit 24+(3-n) enables the receive interrupt of incoming slot n. The side's interrupt rises one cycle after an enabled slot becomes full. Full slots that are not enabled do not raise it: with only slot 3 enabled, a four-word message raises the interrupt only after its fourth word.
- R5: Control bit 20+(3-n) enables the transmit interrupt of outgoing slot n. The interrupt is asserted while that slot's empty flag is 1, one cycle delayed.
- R6: Writing 1 to control bit 16+(3-n) sets doorbell request n. The bit reads back as 1 for exactly one cycle and then clears by itself. In that same cycle it sets pending bit 28+(3-n) in the other side's status word. A pending bit is cleared only by writing 1 to it in the status word; writing 0 leaves it alone.
- R7: Control bit 28+(3-n) enables pending doorbell n to drive the side's interrupt, one cycle delayed.
- R8: After reset the status word on each side reads 0x00F00000, the control word reads 0, and both interrupts are low.
- R9: Writing 0 to the control word switches off every interrupt enable, so the interrupt is low one cycle later whatever the flags are.
- R10: Writes to incoming-slot offsets have no effect. Writes to the status word change only the pending bits.
- R11: If a side writes outgoing slot n in the same cycle that the partner reads incoming slot n, the read returns the old word, the full flag stays 1, and the next read returns the new word.
- R12: Read data is 0 whenever read enable is low. Reading an outgoing slot returns the word last written there by the same side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| a_addr | input | 6 | Side A byte offset |
| a_wdata | input | 32 | Side A write data |
| a_we | input | 1 | Side A write enable |
| a_re | input | 1 | Side A read enable |
| a_rdata | output | 32 | Side A read data (combinational, 0 when a_re is low) |
| a_irq | output | 1 | Side A interrupt |
| b_addr | input | 6 | Side B byte offset |
| b_wdata | input | 32 | Side B write data |
| b_we | input | 1 | Side B write enable |
| b_re | input | 1 | Side B read enable |
| b_rdata | output | 32 | Side B read data (combinational, 0 when b_re is low) |
| b_irq | output | 1 | Side B interrupt |

## Verification
The bench targets the reversed bit layout of every field. A design that put slot n at bit base+n would report the wrong flag and enable the wrong interrupt. It also sends a four-word message with only the last slot enabled; an unmasked design would interrupt on the first word. It checks that a doorbell request lasts one cycle and that its pending bit survives a write of 0. A design with a level request, or one that clears the pending bit on any write, would retrigger or lose the event. It covers a write and a partner read of the same slot in one cycle, where a clear-priority flag would drop the new word.

// File: rtl/ipcm_pkg.sv
// Package: shared constants of the two-sided messaging unit.
// Holds the register window offsets and the base bit of each
// reversed four-bit field in the status and control words.
package ipcm_pkg;
    localparam int NUM_SLOTS = 4;
    localparam int WORD_W    = 32;
    localparam int OFS_W     = 6;

    localparam logic [OFS_W-1:0] OFS_OUT0 = 6'h00;
    localparam logic [OFS_W-1:0] OFS_IN0  = 6'h10;
    localparam logic [OFS_W-1:0] OFS_STAT = 6'h20;
    localparam logic [OFS_W-1:0] OFS_CTRL = 6'h24;

    // Base bits; slot n of a field sits at base+(NUM_SLOTS-1-n).
    localparam int FLD_BELL  = 16;  // control: doorbell request
    localparam int FLD_EMPTY = 20;  // status: empty / control: tx enable
    localparam int FLD_FULL  = 24;  // status: full  / control: rx enable
    localparam int FLD_PEND  = 28;  // status: pending / control: bell enable
endpackage

// File: rtl/ipcm_channel.sv
// Module: ipcm_channel
// One direction of the data path: a bank of slots with a full flag each.
// The sender writes a slot and the receiver's read of it empties it.
// Assumes: one shared clock. A write and a read of the same slot in one
// cycle leave the slot full, holding the new word.
module ipcm_channel #(
    parameter int WORD_W    = ipcm_pkg::WORD_W,
    parameter int NUM_SLOTS = ipcm_pkg::NUM_SLOTS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SLOTS-1:0]        wr_stb,
    input  logic [WORD_W-1:0]           wr_word,
    input  logic [NUM_SLOTS-1:0]        rd_stb,
    output logic [NUM_SLOTS-1:0]        full,
    output logic [NUM_SLOTS*WORD_W-1:0] words
);
    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
        logic [WORD_W-1:0] word_q;
        logic              full_q;

        // Capture the sender's word on a write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)         word_q <= '0;
            else if (wr_stb[n]) word_q <= wr_word;
        end

        // Full flag: a write sets it and wins over a same-cycle read.
        always_ff @(posedge clk) begin
            if (!rst_n)         full_q <= 1'b0;
            else if (wr_stb[n]) full_q <= 1'b1;
            else if (rd_stb[n]) full_q <= 1'b0;
        end

        assign full[n]                    = full_q;
        assign words[n*WORD_W +: WORD_W]  = word_q;

        // R3: a slot is full right after its write
        a_r3_fill: assert property (@(posedge clk) disable iff (!rst_n)
            wr_stb[n] |=> full[n]);
        // R2: a lone read empties the slot
        a_r2_drain: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_stb[n] && !wr_stb[n]) |=> !full[n]);
        // R11: the written word is what the slot holds afterwards
        a_r11_word: assert property (@(posedge clk) disable iff (!rst_n)
            wr_stb[n] |=> (words[n*WORD_W +: WORD_W] == $past(wr_word)));
    end
endmodule

// File: rtl/ipcm_side.sv
// Module: ipcm_side
// One side's register window: address decode, control word, doorbell
// requests and pending bits, the read mux and the interrupt register.
// Assumes: fields use reversed slot order (slot n at base+NUM_SLOTS-1-n).
// Read data is combinational and 0 when read enable is low.
module ipcm_side #(
    parameter int WORD_W    = ipcm_pkg::WORD_W,
    parameter int NUM_SLOTS = ipcm_pkg::NUM_SLOTS,
    parameter int OFS_W     = ipcm_pkg::OFS_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [OFS_W-1:0]            addr,
    input  logic [WORD_W-1:0]           wdata,
    input  logic                        we,
    input  logic                        re,
    output logic [WORD_W-1:0]           rdata,
    output logic                        irq,
    input  logic [NUM_SLOTS-1:0]        out_full,
    input  logic [NUM_SLOTS*WORD_W-1:0] out_words,
    input  logic [NUM_SLOTS-1:0]        in_full,
    input  logic [NUM_SLOTS*WORD_W-1:0] in_words,
    output logic [NUM_SLOTS-1:0]        out_wr,
    output logic [NUM_SLOTS-1:0]        in_rd,
    input  logic [NUM_SLOTS-1:0]        peer_bell,
    output logic [NUM_SLOTS-1:0]        own_bell
);
    import ipcm_pkg::*;

    localparam int SLOT_STRIDE = 4;

    // Reverse a slot-indexed vector into field bit order and back.
    function automatic logic [NUM_SLOTS-1:0] flip(input logic [NUM_SLOTS-1:0] v);
        logic [NUM_SLOTS-1:0] r;
        for (int i = 0; i < NUM_SLOTS; i++) r[i] = v[NUM_SLOTS-1-i];
        return r;
    endfunction

    logic [NUM_SLOTS-1:0] hit_out, hit_in;
    logic                 hit_stat, hit_ctrl;
    logic [NUM_SLOTS-1:0] tx_en_q, rx_en_q, bell_en_q, bell_q, pend_q;
    logic                 irq_q;
    logic [WORD_W-1:0]    stat_word, ctrl_word;

    // Decode the offset into slot, status and control hits.
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            hit_out[i] = (addr == OFS_OUT0 + OFS_W'(i * SLOT_STRIDE));
            hit_in[i]  = (addr == OFS_IN0  + OFS_W'(i * SLOT_STRIDE));
        end
        hit_stat = (addr == OFS_STAT);
        hit_ctrl = (addr == OFS_CTRL);
    end

    assign out_wr = we ? hit_out : '0;
    assign in_rd  = re ? hit_in  : '0;

    // Control word: enables load on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q   <= '0;
            rx_en_q   <= '0;
            bell_en_q <= '0;
        end else if (we && hit_ctrl) begin
            tx_en_q   <= flip(wdata[FLD_EMPTY +: NUM_SLOTS]);
            rx_en_q   <= flip(wdata[FLD_FULL  +: NUM_SLOTS]);
            bell_en_q <= flip(wdata[FLD_PEND  +: NUM_SLOTS]);
        end
    end

    // Doorbell request: lives for one cycle after the control write.
    always_ff @(posedge clk) begin
        if (!rst_n)                bell_q <= '0;
        else if (we && hit_ctrl)   bell_q <= flip(wdata[FLD_BELL +: NUM_SLOTS]);
        else                       bell_q <= '0;
    end

    assign own_bell = bell_q;

    // Pending doorbells: set by the partner's request, cleared by write-1.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~((we && hit_stat) ? flip(wdata[FLD_PEND +: NUM_SLOTS]) : '0))
                              | peer_bell;
    end

    // Assemble the status and control read values.
    always_comb begin
        stat_word = '0;
        stat_word[FLD_EMPTY +: NUM_SLOTS] = flip(~out_full);
        stat_word[FLD_FULL  +: NUM_SLOTS] = flip(in_full);
        stat_word[FLD_PEND  +: NUM_SLOTS] = flip(pend_q);
        ctrl_word = '0;
        ctrl_word[FLD_BELL  +: NUM_SLOTS] = flip(bell_q);
        ctrl_word[FLD_EMPTY +: NUM_SLOTS] = flip(tx_en_q);
        ctrl_word[FLD_FULL  +: NUM_SLOTS] = flip(rx_en_q);
        ctrl_word[FLD_PEND  +: NUM_SLOTS] = flip(bell_en_q);
    end

    // Read mux: selected register, or 0 without a read.
    always_comb begin
        rdata = '0;
        if (re) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (hit_out[i]) rdata = out_words[i*WORD_W +: WORD_W];
                if (hit_in[i])  rdata = in_words[i*WORD_W +: WORD_W];
            end
            if (hit_stat) rdata = stat_word;
            if (hit_ctrl) rdata = ctrl_word;
        end
    end

    // Interrupt: registered OR of all enabled sources.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(tx_en_q & ~out_full) | |(rx_en_q & in_full) | |(bell_en_q & pend_q);
    end

    assign irq = irq_q;

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_chk
        // R6: a request lasts one cycle unless rewritten
        a_r6_bell_once: assert property (@(posedge clk) disable iff (!rst_n)
            (own_bell[n] && !(we && hit_ctrl)) |=> !own_bell[n]);
        // R6: a partner request always lands as pending
        a_r6_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
            peer_bell[n] |=> pend_q[n]);
        // R4: an enabled full slot raises the interrupt next cycle
        a_r4_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_en_q[n] && in_full[n]) |=> irq);
        // R5: an enabled empty slot raises the interrupt next cycle
        a_r5_tx_irq: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_en_q[n] && !out_full[n]) |=> irq);
    end
    // R9: with every enable off the interrupt is low next cycle
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_q == '0 && rx_en_q == '0 && bell_en_q == '0) |=> !irq);
    // R12: no read, no data
    a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !re |-> (rdata == '0));
endmodule

// File: rtl/ipcm_top.sv
// Module: ipcm_top
// Two-sided messaging unit: two register windows joined by one data
// channel per direction and cross-wired doorbells.
// Assumes: both sides run on clk; synchronous active-low reset.
module ipcm_top #(
    parameter int WORD_W    = ipcm_pkg::WORD_W,
    parameter int NUM_SLOTS = ipcm_pkg::NUM_SLOTS,
    parameter int OFS_W     = ipcm_pkg::OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  a_addr,
    input  logic [WORD_W-1:0] a_wdata,
    input  logic              a_we,
    input  logic              a_re,
    output logic [WORD_W-1:0] a_rdata,
    output logic              a_irq,
    input  logic [OFS_W-1:0]  b_addr,
    input  logic [WORD_W-1:0] b_wdata,
    input  logic              b_we,
    input  logic              b_re,
    output logic [WORD_W-1:0] b_rdata,
    output logic              b_irq
);
    logic [NUM_SLOTS-1:0]        ab_full, ba_full, a_wr, b_wr, a_rd, b_rd, a_bell, b_bell;
    logic [NUM_SLOTS*WORD_W-1:0] ab_words, ba_words;

    ipcm_channel #(.WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS)) u_a2b (
        .clk(clk), .rst_n(rst_n), .wr_stb(a_wr), .wr_word(a_wdata),
        .rd_stb(b_rd), .full(ab_full), .words(ab_words));

    ipcm_channel #(.WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS)) u_b2a (
        .clk(clk), .rst_n(rst_n), .wr_stb(b_wr), .wr_word(b_wdata),
        .rd_stb(a_rd), .full(ba_full), .words(ba_words));

    ipcm_side #(.WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS), .OFS_W(OFS_W)) u_side_a (
        .clk(clk), .rst_n(rst_n), .addr(a_addr), .wdata(a_wdata), .we(a_we), .re(a_re),
        .rdata(a_rdata), .irq(a_irq),
        .out_full(ab_full), .out_words(ab_words), .in_full(ba_full), .in_words(ba_words),
        .out_wr(a_wr), .in_rd(a_rd), .peer_bell(b_bell), .own_bell(a_bell));

    ipcm_side #(.WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS), .OFS_W(OFS_W)) u_side_b (
        .clk(clk), .rst_n(rst_n), .addr(b_addr), .wdata(b_wdata), .we(b_we), .re(b_re),
        .rdata(b_rdata), .irq(b_irq),
        .out_full(ba_full), .out_words(ba_words), .in_full(ab_full), .in_words(ab_words),
        .out_wr(b_wr), .in_rd(b_rd), .peer_bell(a_bell), .own_bell(b_bell));
endmodule

// File: tb/ipcm_top_tb_top.sv
// Bench: behavioural model of both sides, compared on every clock,
// plus directed checks per requirement.
module ipcm_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [5:0]  t_addr [2];
    logic [31:0] t_wd   [2];
    logic        t_we   [2];
    logic        t_re   [2];
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    ipcm_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_addr(t_addr[0]), .a_wdata(t_wd[0]), .a_we(t_we[0]), .a_re(t_re[0]),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_addr(t_addr[1]), .b_wdata(t_wd[1]), .b_we(t_we[1]), .b_re(t_re[1]),
        .b_rdata(b_rdata), .b_irq(b_irq));

    // Model state: m_data[s][n] is the word side s last wrote to slot n.
    logic [31:0] m_data [2][4];
    bit          m_full [2][4];
    logic [31:0] m_ctrl [2];
    bit          m_pend [2][4];
    bit          m_irq  [2];

    int     n_cmp = 0, n_bad = 0;
    string  cur_req = "R8";
    logic [31:0] s_rdata [2];
    bit          s_irq   [2];
    bit          done = 0;

    function automatic logic [31:0] m_stat(int s);
        logic [31:0] v = '0;
        for (int n = 0; n < 4; n++) begin
            if (!m_full[s][n])   v[20+3-n] = 1'b1;
            if (m_full[1-s][n])  v[24+3-n] = 1'b1;
            if (m_pend[s][n])    v[28+3-n] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [31:0] m_read(int s);
        if (!t_re[s]) return '0;
        for (int n = 0; n < 4; n++) begin
            if (t_addr[s] == 6'(4*n))      return m_data[s][n];
            if (t_addr[s] == 6'(16+4*n))   return m_data[1-s][n];
        end
        if (t_addr[s] == 6'h20) return m_stat(s);
        if (t_addr[s] == 6'h24) return m_ctrl[s];
        return '0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 2; s++) begin
            m_ctrl[s] = '0; m_irq[s] = 0;
            for (int n = 0; n < 4; n++) begin
                m_data[s][n] = '0; m_full[s][n] = 0; m_pend[s][n] = 0;
            end
        end
    endtask

    task automatic model_step();
        bit          irq_new [2];
        logic [3:0]  req_old [2];
        bit          rd_hit  [2][4];
        for (int s = 0; s < 2; s++) begin
            irq_new[s] = |(m_ctrl[s][31:20] & m_stat(s)[31:20]);
            req_old[s] = m_ctrl[s][19:16];
            for (int n = 0; n < 4; n++)
                rd_hit[s][n] = t_re[s] && (t_addr[s] == 6'(16+4*n));
        end
        for (int s = 0; s < 2; s++) begin
            for (int n = 0; n < 4; n++) begin
                bit wr = t_we[s] && (t_addr[s] == 6'(4*n));
                if (rd_hit[1-s][n]) m_full[s][n] = 0;
                if (wr) begin m_full[s][n] = 1; m_data[s][n] = t_wd[s]; end
                if (t_we[s] && t_addr[s] == 6'h20 && t_wd[s][28+3-n]) m_pend[s][n] = 0;
                if (req_old[1-s][3-n]) m_pend[s][n] = 1;
            end
            if (t_we[s] && t_addr[s] == 6'h24) m_ctrl[s] = t_wd[s] & 32'hFFFF0000;
            else                               m_ctrl[s][19:16] = 4'h0;
            m_irq[s] = irq_new[s];
        end
    endtask

    // One clock: sample and compare before the edge, then advance the model.
    task automatic tick();
        #5;
        s_rdata[0] = a_rdata; s_rdata[1] = b_rdata;
        s_irq[0]   = a_irq;   s_irq[1]   = b_irq;
        for (int s = 0; s < 2; s++) begin
            check({cur_req, " model rdata"}, s_rdata[s], m_read(s));
            check({cur_req, " model irq"}, {31'd0, s_irq[s]}, {31'd0, m_irq[s]});
        end
        @(posedge clk);
        if (!rst_n) model_reset(); else model_step();
        @(negedge clk);
    endtask

    task automatic quiet();
        for (int s = 0; s < 2; s++) begin
            t_we[s] = 0; t_re[s] = 0; t_addr[s] = '0; t_wd[s] = '0;
        end
    endtask

    task automatic wr(int s, logic [5:0] a, logic [31:0] d);
        quiet(); t_we[s] = 1; t_addr[s] = a; t_wd[s] = d; tick(); quiet();
    endtask

    task automatic rd(int s, logic [5:0] a, output logic [31:0] d);
        quiet(); t_re[s] = 1; t_addr[s] = a; tick(); d = s_rdata[s]; quiet();
    endtask

    task automatic idle(int k);
        quiet();
        for (int i = 0; i < k; i++) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        quiet();
        model_reset();
        @(negedge clk);
        rst_n = 0;
        idle(3);
        rst_n = 1;
        idle(1);

        // R8 reset state
        cur_req = "R8";
        rd(0, 6'h20, v); check("R8 A status", v, 32'h00F00000);
        rd(1, 6'h24, v); check("R8 B ctrl", v, 32'h0);
        check("R8 irq", {30'd0, s_irq[0], s_irq[1]}, 32'h0);

        // R1 A to B message, R3 full flags, R2 empty flags
        cur_req = "R1";
        for (int n = 0; n < 4; n++) wr(0, 6'(4*n), 32'hA0000000 + n);
        cur_req = "R3";
        rd(1, 6'h20, v); check("R3 B status full", v, 32'h0FF00000);
        cur_req = "R2";
        rd(0, 6'h20, v); check("R2 A status empty clear", v, 32'h00000000);
        cur_req = "R1";
        for (int n = 0; n < 4; n++) begin
            rd(1, 6'(16+4*n), v); check("R1 B reads A word", v, 32'hA0000000 + n);
        end
        cur_req = "R2";
        rd(0, 6'h20, v); check("R2 A empty after partner read", v, 32'h00F00000);
        cur_req = "R3";
        rd(1, 6'h1C, v); check("R3 stale read", v, 32'hA0000003);
        cur_req = "R1";
        wr(1, 6'h04, 32'h13572468);
        rd(0, 6'h14, v); check("R1 A reads B word", v, 32'h13572468);

        // R4 masked multi-word message: only slot 3 enabled on B
        cur_req = "R4";
        wr(1, 6'h24, 32'h01000000);
        for (int n = 0; n < 3; n++) begin
            wr(0, 6'(4*n), 32'hB0000000 + n);
            idle(1);
            check("R4 no irq before last word", {31'd0, s_irq[1]}, 32'h0);
        end
        wr(0, 6'h0C, 32'hB0000003);
        idle(2);
        check("R4 irq on last word", {31'd0, s_irq[1]}, 32'h1);
        for (int n = 0; n < 4; n++) rd(1, 6'(16+4*n), v);
        idle(2);
        check("R4 irq drops after reads", {31'd0, s_irq[1]}, 32'h0);

        // R5 transmit-empty interrupt on slot 0 of A
        cur_req = "R5";
        wr(0, 6'h24, 32'h00800000);
        idle(2);
        check("R5 irq while empty", {31'd0, s_irq[0]}, 32'h1);
        wr(0, 6'h00, 32'hC0FFEE00);
        idle(2);
        check("R5 irq off while full", {31'd0, s_irq[0]}, 32'h0);
        rd(1, 6'h10, v);
        idle(2);
        check("R5 irq back after drain", {31'd0, s_irq[0]}, 32'h1);

        // R9 control write of zero
        cur_req = "R9";
        wr(0, 6'h24, 32'h0);
        idle(2);
        check("R9 irq off", {31'd0, s_irq[0]}, 32'h0);

        // R6 doorbell 0 from A, R7 enable on B
        cur_req = "R6";
        wr(0, 6'h24, 32'h00080000);
        rd(0, 6'h24, v); check("R6 request visible one cycle", v, 32'h00080000);
        rd(1, 6'h20, v); check("R6 pending on partner", v, 32'h80F00000);
        rd(0, 6'h24, v); check("R6 request self-cleared", v, 32'h0);
        wr(1, 6'h20, 32'h0);
        rd(1, 6'h20, v); check("R6 write 0 keeps pending", v, 32'h80F00000);
        cur_req = "R7";
        wr(1, 6'h24, 32'h80000000);
        idle(2);
        check("R7 bell irq", {31'd0, s_irq[1]}, 32'h1);
        cur_req = "R6";
        wr(1, 6'h20, 32'h80000000);
        idle(2);
        check("R6 clear drops irq", {31'd0, s_irq[1]}, 32'h0);
        rd(1, 6'h20, v); check("R6 pending cleared", v, 32'h00F00000);
        wr(1, 6'h24, 32'h00020000);
        idle(1);
        rd(0, 6'h20, v); check("R6 bell 2 to A", v, 32'h20F00000);
        wr(0, 6'h20, 32'h20000000);
        rd(0, 6'h20, v); check("R6 bell 2 cleared", v, 32'h00F00000);

        // R10 ignored writes
        cur_req = "R10";
        wr(1, 6'h14, 32'hDEADBEEF);
        rd(1, 6'h14, v); check("R10 incoming slot unchanged", v, 32'hB0000001);
        wr(1, 6'h20, 32'h0FFFFFFF);
        rd(1, 6'h20, v); check("R10 status flags unchanged", v, 32'h00F00000);

        // R11 write and partner read of the same slot together
        cur_req = "R11";
        wr(0, 6'h08, 32'h11111111);
        quiet();
        t_we[0] = 1; t_addr[0] = 6'h08; t_wd[0] = 32'h22222222;
        t_re[1] = 1; t_addr[1] = 6'h18;
        tick();
        check("R11 read returns old word", s_rdata[1], 32'h11111111);
        quiet();
        rd(1, 6'h20, v); check("R11 full stays set", v, 32'h02F00000);
        rd(0, 6'h20, v); check("R11 sender empty clear", v, 32'h00D00000);
        rd(1, 6'h18, v); check("R11 new word", v, 32'h22222222);

        // R12 read data gating and outgoing readback
        cur_req = "R12";
        rd(0, 6'h08, v); check("R12 outgoing readback", v, 32'h22222222);
        quiet(); t_addr[0] = 6'h08; tick();
        check("R12 zero without read", s_rdata[0], 32'h0);
        idle(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule